// File: doc/BRIEF.md
# Implicit-Zero Byte-Flagged Line Store

This block is a small on-chip line store in which freshly allocated memory reads as zero without any initialising write. Every byte of every line carries a "fresh" flag. Allocating a line sets all of its flags and touches no data and no backing memory. A load builds its result byte by byte: a flagged byte reads as zero, whatever the data array holds, and an unflagged byte reads as the stored data. A byte-masked store writes the selected bytes and clears the flag of exactly those bytes.

The block has three request paths that work in the same cycle. The allocate path and the store path take a request every cycle. The load path uses a valid/ready handshake on the request side and on the response side. A small load controller has three states. LD_IDLE takes a load (ld_ready high). An accepted load to an allocated line moves it to LD_DATA. An accepted load to an unallocated line moves it to LD_FAULT. Both holding states present the response and return to LD_IDLE once rd_ready is high. A status output tells whether a chosen line is allocated and still entirely fresh, so that evicting it would need no writeback.

Top module: `iz_line_store`

## Requirements
- R1: After reset every line is unallocated, chk_clean is 0 for every index, rd_valid is 0 and ld_ready is 1.
- R2: An allocate sets the line allocated and flags all 64 bytes fresh. From the next cycle a load of that line returns all zeros, even if the line held stored data before.
- R3: A load returns, for each byte b (bits 8b+7..8b of rd_data), zero if byte b is flagged fresh and the stored byte otherwise.
- R4: A store writes st_data byte b and clears its flag only where st_mask bit b is 1. Bytes with a mask bit of 0 keep both their data and their flag.
- R5: chk_clean is 1 exactly when line chk_idx is allocated and all 64 of its flags are set. Any store with a non-zero mask to that line clears it.
- R6: A load accepted in the same cycle as a store to the same line returns the values from before the store. The store is visible to loads accepted from the next cycle on.
- R7: A load of an unallocated line gives a response with rd_err = 1 and rd_data = 0. A store to an unallocated line raises st_err for exactly one cycle, in the cycle after the store, and changes no state.
- R8: While a response is held (rd_valid = 1 and rd_ready = 0), rd_data and rd_err stay stable and ld_ready is 0. Each accepted load yields exactly one response.
- R9: If an allocate and a store target the same line in the same cycle, the allocate wins. The store is discarded and st_err stays 0.
- R10: A store with an all-zero mask leaves the line's data, flags and chk_clean unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| al_valid | input | 1 | Allocate request |
| al_idx | input | 3 | Line to allocate |
| st_valid | input | 1 | Store request |
| st_idx | input | 3 | Line to store to |
| st_mask | input | 64 | Byte enables, bit b selects byte b |
| st_data | input | 512 | Store data, byte b in bits 8b+7..8b |
| st_err | output | 1 | One-cycle pulse after a store to an unallocated line |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted when high with ld_valid |
| ld_idx | input | 3 | Line to load |
| rd_valid | output | 1 | Load response valid |
| rd_ready | input | 1 | Load response taken |
| rd_err | output | 1 | Response is for an unallocated line |
| rd_data | output | 512 | Merged line data |
| chk_idx | input | 3 | Line queried for status |
| chk_clean | output | 1 | Queried line allocated and entirely fresh |

## Verification
Loads are tried on a line that was never allocated, on a line that was just allocated, on a line after a partial store of the low eight bytes, and on a line after a second store of scattered bytes. Together these separate the fault path, the all-zero fresh path and the byte-by-byte merge. A store and a load to the same line in one cycle shows whether the load sees the old values. An allocate and a store together, a zero-mask store, and a re-allocation of a written line show which operation wins and that the flags alone decide what a read returns. A response held for several cycles while a new load waits shows whether rd_data stays stable and whether the waiting load is blocked.

// File: rtl/iz_pkg.sv
package iz_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_DATA  = 2'd1,
        LD_FAULT = 2'd2
    } ld_state_e;

    // Per-byte merge: a fresh byte reads as zero.
    function automatic logic [511:0] merge_fresh(input logic [511:0] raw,
                                                 input logic [63:0]  fresh);
        logic [511:0] r;
        for (int b = 0; b < 64; b++) begin
            r[b*8 +: 8] = fresh[b] ? 8'h00 : raw[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/iz_flag_bank.sv
module iz_flag_bank #(
    parameter int LINES = 8,
    parameter int BYTES = 64,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         al_en,
    input  logic [IDXW-1:0]              al_idx,
    input  logic                         st_en,
    input  logic [IDXW-1:0]              st_idx,
    input  logic [BYTES-1:0]             st_mask,
    output logic [LINES-1:0]             alloc_q,
    output logic [LINES-1:0][BYTES-1:0]  fresh_q
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alloc_q[i] <= 1'b0;
                fresh_q[i] <= '0;
            end else if (al_en && al_idx == IDXW'(i)) begin
                alloc_q[i] <= 1'b1;
                fresh_q[i] <= '1;
            end else if (st_en && st_idx == IDXW'(i)) begin
                fresh_q[i] <= fresh_q[i] & ~st_mask;
            end
        end
    end
endmodule

// File: rtl/iz_data_bank.sv
module iz_data_bank #(
    parameter int LINES = 8,
    parameter int BYTES = 64,
    localparam int IDXW = $clog2(LINES),
    localparam int DW   = BYTES * 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IDXW-1:0]      w_idx,
    input  logic [BYTES-1:0]     w_mask,
    input  logic [DW-1:0]        w_data,
    input  logic [IDXW-1:0]      r_idx,
    output logic [DW-1:0]        r_data
);
    logic [LINES-1:0][DW-1:0] mem_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (we && w_idx == IDXW'(i)) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (w_mask[b]) mem_q[i][b*8 +: 8] <= w_data[b*8 +: 8];
                end
            end
        end
    end

    assign r_data = mem_q[r_idx];
endmodule

// File: rtl/iz_load_fsm.sv
module iz_load_fsm
    import iz_pkg::*;
#(
    parameter int DW = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          line_ok,
    input  logic [DW-1:0] merged,
    input  logic          rd_ready,
    output logic          ld_ready,
    output logic          rd_valid,
    output logic          rd_err,
    output logic [DW-1:0] rd_data
);
    ld_state_e state_q, state_d;
    logic      accept;
    logic [DW-1:0] data_q;

    assign accept = ld_valid && (state_q == LD_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (accept) state_d = line_ok ? LD_DATA : LD_FAULT;
            LD_DATA:  if (rd_ready) state_d = LD_IDLE;
            LD_FAULT: if (rd_ready) state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= line_ok ? merged : '0;
    end

    always_comb begin
        ld_ready = (state_q == LD_IDLE);
        rd_valid = (state_q == LD_DATA) || (state_q == LD_FAULT);
        rd_err   = (state_q == LD_FAULT);
        rd_data  = data_q;
    end
endmodule

// File: rtl/iz_line_store.sv
module iz_line_store
    import iz_pkg::*;
#(
    parameter int LINES = 8,
    parameter int BYTES = 64,
    localparam int IDXW = $clog2(LINES),
    localparam int DW   = BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             al_valid,
    input  logic [IDXW-1:0]  al_idx,
    input  logic             st_valid,
    input  logic [IDXW-1:0]  st_idx,
    input  logic [BYTES-1:0] st_mask,
    input  logic [DW-1:0]    st_data,
    output logic             st_err,
    input  logic             ld_valid,
    output logic             ld_ready,
    input  logic [IDXW-1:0]  ld_idx,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             rd_err,
    output logic [DW-1:0]    rd_data,
    input  logic [IDXW-1:0]  chk_idx,
    output logic             chk_clean
);
    logic [LINES-1:0]            alloc_q;
    logic [LINES-1:0][BYTES-1:0] fresh_q;
    logic [DW-1:0]               raw_line;
    logic [DW-1:0]               merged;
    logic                        st_clash;
    logic                        st_ok;
    logic                        st_err_q;

    // An allocate to the same line in the same cycle overrides the store.
    assign st_clash = al_valid && (al_idx == st_idx);
    assign st_ok    = st_valid && !st_clash && alloc_q[st_idx];

    iz_flag_bank #(.LINES(LINES), .BYTES(BYTES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .al_en   (al_valid),
        .al_idx  (al_idx),
        .st_en   (st_ok),
        .st_idx  (st_idx),
        .st_mask (st_mask),
        .alloc_q (alloc_q),
        .fresh_q (fresh_q)
    );

    iz_data_bank #(.LINES(LINES), .BYTES(BYTES)) u_data (
        .clk    (clk),
        .we     (st_ok),
        .w_idx  (st_idx),
        .w_mask (st_mask),
        .w_data (st_data),
        .r_idx  (ld_idx),
        .r_data (raw_line)
    );

    always_comb begin
        for (int b = 0; b < BYTES; b++) begin
            merged[b*8 +: 8] = fresh_q[ld_idx][b] ? 8'h00 : raw_line[b*8 +: 8];
        end
    end

    iz_load_fsm #(.DW(DW)) u_ld (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .line_ok  (alloc_q[ld_idx]),
        .merged   (merged),
        .rd_ready (rd_ready),
        .ld_ready (ld_ready),
        .rd_valid (rd_valid),
        .rd_err   (rd_err),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_err_q <= 1'b0;
        else        st_err_q <= st_valid && !st_clash && !alloc_q[st_idx];
    end
    assign st_err = st_err_q;

    assign chk_clean = alloc_q[chk_idx] && (&fresh_q[chk_idx]);
endmodule

// File: rtl/iz_line_store_chk.sv
module iz_line_store_chk #(
    parameter int IDXW = 3,
    parameter int DW   = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic            al_valid,
    input logic [IDXW-1:0] al_idx,
    input logic            st_valid,
    input logic            st_err,
    input logic            ld_valid,
    input logic            ld_ready,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic            rd_err,
    input logic [DW-1:0]   rd_data,
    input logic [IDXW-1:0] chk_idx,
    input logic            chk_clean
);
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_err));

    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !ld_ready);

    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_err |-> rd_data == '0);

    a_r7_err_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> $past(st_valid));

    a_r2_alloc_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $past(al_valid) && $past(rst_n) && chk_idx == $past(al_idx) |-> chk_clean);

    a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_ready |=> rd_valid);
endmodule

bind iz_line_store iz_line_store_chk #(.IDXW(IDXW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .al_valid  (al_valid),
    .al_idx    (al_idx),
    .st_valid  (st_valid),
    .st_err    (st_err),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_err    (rd_err),
    .rd_data   (rd_data),
    .chk_idx   (chk_idx),
    .chk_clean (chk_clean)
);

// File: tb/iz_line_store_test.sv
`timescale 1ns/1ps
module iz_line_store_test;
    localparam int LINES = 8;
    localparam int BYTES = 64;
    localparam int DW    = BYTES * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic al_valid = 0; logic [2:0] al_idx = 0;
    logic st_valid = 0; logic [2:0] st_idx = 0;
    logic [BYTES-1:0] st_mask = 0; logic [DW-1:0] st_data = 0;
    logic st_err;
    logic ld_valid = 0; logic ld_ready; logic [2:0] ld_idx = 0;
    logic rd_valid; logic rd_ready = 0; logic rd_err; logic [DW-1:0] rd_data;
    logic [2:0] chk_idx = 0; logic chk_clean;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model built from the requirements
    logic [DW-1:0]    m_data  [LINES];
    logic [BYTES-1:0] m_fresh [LINES];

    always #2.5 clk = ~clk;

    iz_line_store uut (
        .clk(clk), .rst_n(rst_n),
        .al_valid(al_valid), .al_idx(al_idx),
        .st_valid(st_valid), .st_idx(st_idx), .st_mask(st_mask), .st_data(st_data),
        .st_err(st_err),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_idx(ld_idx),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_err(rd_err), .rd_data(rd_data),
        .chk_idx(chk_idx), .chk_clean(chk_clean)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_line(input int i);
        logic [DW-1:0] r;
        for (int b = 0; b < BYTES; b++)
            r[b*8 +: 8] = m_fresh[i][b] ? 8'h00 : m_data[i][b*8 +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] pattern(input int seed);
        logic [DW-1:0] r;
        for (int b = 0; b < BYTES; b++) r[b*8 +: 8] = 8'(seed * 37 + b * 11 + 1);
        return r;
    endfunction

    task automatic model_store(input int i, input logic [BYTES-1:0] m, input logic [DW-1:0] d);
        for (int b = 0; b < BYTES; b++)
            if (m[b]) begin
                m_data[i][b*8 +: 8] = d[b*8 +: 8];
                m_fresh[i][b] = 1'b0;
            end
    endtask

    task automatic do_alloc(input int i);
        al_valid = 1; al_idx = 3'(i);
        @(negedge clk);
        al_valid = 0;
        m_fresh[i] = '1;
    endtask

    task automatic do_store(input int i, input logic [BYTES-1:0] m, input logic [DW-1:0] d);
        st_valid = 1; st_idx = 3'(i); st_mask = m; st_data = d;
        @(negedge clk);
        st_valid = 0; st_mask = '0;
    endtask

    // Issues a load, waits for the response, returns it and completes the handshake.
    task automatic do_load(input int i, output logic [DW-1:0] d, output logic e);
        ld_valid = 1; ld_idx = 3'(i);
        @(negedge clk);
        ld_valid = 0;
        check("R8 response after accept", DW'(rd_valid), DW'(1));
        d = rd_data; e = rd_err;
        rd_ready = 1;
        @(negedge clk);
        rd_ready = 0;
        check("R8 single response", DW'(rd_valid), DW'(0));
    endtask

    task automatic t_r1_reset();
        check("R1 rd_valid", DW'(rd_valid), DW'(0));
        check("R1 ld_ready", DW'(ld_ready), DW'(1));
        for (int i = 0; i < LINES; i++) begin
            chk_idx = 3'(i); #0.1;
            check("R1 chk_clean", DW'(chk_clean), DW'(0));
        end
    endtask

    task automatic t_r7_unallocated();
        logic [DW-1:0] d; logic e;
        do_load(3, d, e);
        check("R7 load err", DW'(e), DW'(1));
        check("R7 load data", d, '0);
        do_store(3, '1, pattern(9));
        check("R7 st_err pulse", DW'(st_err), DW'(1));
        @(negedge clk);
        check("R7 st_err one cycle", DW'(st_err), DW'(0));
        chk_idx = 3; #0.1;
        check("R7 no allocation", DW'(chk_clean), DW'(0));
    endtask

    task automatic t_r2_alloc();
        logic [DW-1:0] d; logic e;
        do_alloc(3);
        chk_idx = 3; #0.1;
        check("R2 R5 clean after alloc", DW'(chk_clean), DW'(1));
        do_load(3, d, e);
        check("R2 err", DW'(e), DW'(0));
        check("R2 all zero", d, '0);
    endtask

    task automatic t_r3_r4_partial();
        logic [DW-1:0] d; logic e;
        do_store(3, 64'h0000_0000_0000_00FF, pattern(1));
        check("R4 st_err low", DW'(st_err), DW'(0));
        chk_idx = 3; #0.1;
        check("R5 clean drops", DW'(chk_clean), DW'(0));
        model_store(3, 64'h0000_0000_0000_00FF, pattern(1));
        do_load(3, d, e);
        check("R3 low bytes merged", d, model_line(3));
        do_store(3, 64'h8000_0100_00F0_0003, pattern(2));
        model_store(3, 64'h8000_0100_00F0_0003, pattern(2));
        do_load(3, d, e);
        check("R4 scattered merge", d, model_line(3));
    endtask

    task automatic t_r10_zero_mask();
        logic [DW-1:0] d; logic e;
        do_alloc(5);
        do_store(5, '0, pattern(4));
        chk_idx = 5; #0.1;
        check("R10 clean kept", DW'(chk_clean), DW'(1));
        check("R10 no error", DW'(st_err), DW'(0));
        do_load(5, d, e);
        check("R10 still zero", d, '0);
    endtask

    task automatic t_r6_same_cycle();
        logic [DW-1:0] before_v; logic [DW-1:0] d; logic e;
        before_v = model_line(3);
        st_valid = 1; st_idx = 3; st_mask = '1; st_data = pattern(6);
        ld_valid = 1; ld_idx = 3;
        @(negedge clk);
        st_valid = 0; ld_valid = 0; st_mask = '0;
        model_store(3, '1, pattern(6));
        check("R6 old value seen", rd_data, before_v);
        rd_ready = 1; @(negedge clk); rd_ready = 0;
        do_load(3, d, e);
        check("R6 new value next", d, model_line(3));
    endtask

    task automatic t_r9_clash();
        logic [DW-1:0] d; logic e;
        al_valid = 1; al_idx = 3;
        st_valid = 1; st_idx = 3; st_mask = '1; st_data = pattern(8);
        @(negedge clk);
        al_valid = 0; st_valid = 0; st_mask = '0;
        m_fresh[3] = '1;
        check("R9 no st_err", DW'(st_err), DW'(0));
        chk_idx = 3; #0.1;
        check("R9 alloc wins", DW'(chk_clean), DW'(1));
        do_load(3, d, e);
        check("R9 R2 reallocated reads zero", d, '0);
    endtask

    task automatic t_r8_hold();
        logic [DW-1:0] held;
        do_store(5, 64'hFFFF_0000_0000_0000, pattern(3));
        model_store(5, 64'hFFFF_0000_0000_0000, pattern(3));
        ld_valid = 1; ld_idx = 5;
        @(negedge clk);
        held = rd_data;
        check("R8 first response", held, model_line(5));
        ld_idx = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 data stable", rd_data, held);
            check("R8 ld_ready low", DW'(ld_ready), DW'(0));
            check("R8 err stable", DW'(rd_err), DW'(0));
        end
        ld_valid = 0;
        rd_ready = 1; @(negedge clk); rd_ready = 0;
        check("R8 waiting load not taken", DW'(rd_valid), DW'(0));
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_data[i] = '0; m_fresh[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_r1_reset();
        t_r7_unallocated();
        t_r2_alloc();
        t_r3_r4_partial();
        t_r10_zero_mask();
        t_r6_same_cycle();
        t_r9_clash();
        t_r8_hold();
        report();
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end
endmodule